// File: doc/BRIEF.md
# Rotate, Shift and Bit Unit

A purely combinational datapath slice for a small processor. It takes one operand byte and the current carry flag, and in the same cycle produces the rotated, shifted, nibble-swapped or bit-modified byte. It also produces new zero, subtract, half-carry and carry flag values. A four-bit update mask marks which of those flags the selected operation is allowed to change. The caller merges the new flags into its flag register under that mask, and writes the result back to the operand's home only when the write-enable output is high.

The operand width is a parameter (default 8), and the bit index width is derived from it. A separate input marks the short accumulator-only rotate forms. For those forms the zero flag is always cleared instead of being computed from the result. Fetching the operand from memory and decoding instructions are left to the surrounding core.

Top module: `rsb_unit`

## Requirements
- R1: Operation code 0 rotates left circularly: the old MSB goes to both bit 0 and C. Code 1 rotates right circularly: the old bit 0 goes to both the MSB and C.
- R2: Code 2 rotates left through carry: the old C enters bit 0 and the old MSB becomes C. Code 3 rotates right through carry: the old C enters the MSB and the old bit 0 becomes C.
- R3: Code 4 shifts left and fills bit 0 with 0, and the old MSB becomes C. Code 5 shifts right, keeps the MSB and sends bit 0 to C. Code 6 shifts right, fills the MSB with 0 and sends bit 0 to C.
- R4: For codes 0 to 7, with the short-form input low, Z is set exactly when the result is zero and N and H are 0. The mask is 4'b1111 (bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C) and write-enable is 1.
- R5: With the short-form input high, codes 0 to 3 give Z = 0 whatever the result, with the same result and C as the long form. For every other code the short-form input has no effect.
- R6: Code 7 exchanges the upper and lower halves of the operand, sets Z from the result and clears N, H and C.
- R7: Code 8 tests the bit selected by the index: Z = 1 when that bit is 0, N = 0, H = 1, C output equals the carry input, mask 4'b1110, write-enable 0 and result equal to the operand.
- R8: Code 9 clears and code 10 sets the indexed bit, leaving every other bit unchanged. The mask is 4'b0000 and write-enable is 1.
- R9: Whenever mask bit 0 is 0, the C output equals the carry input. Z, N and H outputs whose mask bit is 0 are driven 0.
- R10: Codes 11 to 15 are no-ops: result equals the operand, mask 4'b0000, write-enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | W | Operand byte |
| cy_i | input | 1 | Current carry flag |
| bidx_i | input | $clog2(W) | Bit index for test, clear and set |
| op_i | input | 4 | Operation code |
| acc_form_i | input | 1 | Marks the short accumulator rotate form |
| res_o | output | W | Result value |
| z_o | output | 1 | New zero flag |
| n_o | output | 1 | New subtract flag |
| h_o | output | 1 | New half-carry flag |
| c_o | output | 1 | New carry flag |
| flg_mask_o | output | 4 | Flag update mask {Z,N,H,C} |
| wr_en_o | output | 1 | Result write-back enable |

## Verification
The short-form marker and the operation select arrive together, so the marker can be raised in the same cycle as a shift, a swap or a bit operation that it must not affect. The bench drives a rotate whose result is zero with the marker both low and high, and checks that only Z differs. It then drives a zero-result left shift with the marker high and checks that Z is still set. It also checks the bit test and bit set/clear with the carry input high, to confirm that the carry passes through untouched whenever the operation cannot change it.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

   typedef enum logic [3:0] {
      OP_ROLC = 4'd0,
      OP_RORC = 4'd1,
      OP_ROLT = 4'd2,
      OP_RORT = 4'd3,
      OP_SHLA = 4'd4,
      OP_SHRA = 4'd5,
      OP_SHRL = 4'd6,
      OP_NSWP = 4'd7,
      OP_BTST = 4'd8,
      OP_BCLR = 4'd9,
      OP_BSET = 4'd10
   } rsb_op_e;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } rsb_flags_t;

   localparam logic [3:0] MASK_ALL  = 4'b1111;
   localparam logic [3:0] MASK_TEST = 4'b1110;
   localparam logic [3:0] MASK_NONE = 4'b0000;

endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter #(
   parameter int W = 8
) (
   input  logic [W-1:0] opnd_i,
   input  logic         cy_i,
   input  logic [3:0]   op_i,
   output logic [W-1:0] res_o,
   output logic         cout_o
);
   import rsb_pkg::*;

   localparam int HALF = W / 2;

   always_comb begin
      res_o  = opnd_i;
      cout_o = cy_i;
      case (op_i)
         OP_ROLC: begin
            res_o  = {opnd_i[W-2:0], opnd_i[W-1]};
            cout_o = opnd_i[W-1];
         end
         OP_RORC: begin
            res_o  = {opnd_i[0], opnd_i[W-1:1]};
            cout_o = opnd_i[0];
         end
         OP_ROLT: begin
            res_o  = {opnd_i[W-2:0], cy_i};
            cout_o = opnd_i[W-1];
         end
         OP_RORT: begin
            res_o  = {cy_i, opnd_i[W-1:1]};
            cout_o = opnd_i[0];
         end
         OP_SHLA: begin
            res_o  = {opnd_i[W-2:0], 1'b0};
            cout_o = opnd_i[W-1];
         end
         OP_SHRA: begin
            res_o  = {opnd_i[W-1], opnd_i[W-1:1]};
            cout_o = opnd_i[0];
         end
         OP_SHRL: begin
            res_o  = {1'b0, opnd_i[W-1:1]};
            cout_o = opnd_i[0];
         end
         OP_NSWP: begin
            res_o  = {opnd_i[HALF-1:0], opnd_i[W-1:HALF]};
            cout_o = 1'b0;
         end
         default: begin
            res_o  = opnd_i;
            cout_o = cy_i;
         end
      endcase
   end

endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop #(
   parameter int W  = 8,
   parameter int IW = 3
) (
   input  logic [W-1:0]  opnd_i,
   input  logic [IW-1:0] bidx_i,
   output logic [W-1:0]  clr_o,
   output logic [W-1:0]  set_o,
   output logic          tbit_o
);

   logic [W-1:0] sel;

   for (genvar i = 0; i < W; i++) begin : g_sel
      assign sel[i] = (bidx_i == IW'(i));
   end

   assign clr_o  = opnd_i & ~sel;
   assign set_o  = opnd_i | sel;
   assign tbit_o = |(opnd_i & sel);

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit #(
   parameter int W  = 8,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  opnd_i,
   input  logic          cy_i,
   input  logic [IW-1:0] bidx_i,
   input  logic [3:0]    op_i,
   input  logic          acc_form_i,
   output logic [W-1:0]  res_o,
   output logic          z_o,
   output logic          n_o,
   output logic          h_o,
   output logic          c_o,
   output logic [3:0]    flg_mask_o,
   output logic          wr_en_o
);
   import rsb_pkg::*;

   if (W < 2 || (W % 2) != 0) begin : g_bad_width
      $error("rsb_unit: W must be even and at least 2");
   end
   if ((1 << IW) != W) begin : g_bad_index
      $error("rsb_unit: W must be a power of two matching IW");
   end

   logic [W-1:0] sh_res;
   logic         sh_co;
   logic [W-1:0] bclr;
   logic [W-1:0] bset;
   logic         tbit;
   rsb_flags_t   fl;

   rsb_shifter #(.W(W)) shf_i (
      .opnd_i (opnd_i),
      .cy_i   (cy_i),
      .op_i   (op_i),
      .res_o  (sh_res),
      .cout_o (sh_co)
   );

   rsb_bitop #(.W(W), .IW(IW)) bop_i (
      .opnd_i (opnd_i),
      .bidx_i (bidx_i),
      .clr_o  (bclr),
      .set_o  (bset),
      .tbit_o (tbit)
   );

   logic is_rot;
   assign is_rot = (op_i <= 4'd3);

   always_comb begin
      res_o      = opnd_i;
      fl         = '{z: 1'b0, n: 1'b0, h: 1'b0, c: cy_i};
      flg_mask_o = MASK_NONE;
      wr_en_o    = 1'b0;
      if (op_i <= 4'd7) begin
         res_o      = sh_res;
         fl.z       = (is_rot && acc_form_i) ? 1'b0 : (sh_res == '0);
         fl.c       = sh_co;
         flg_mask_o = MASK_ALL;
         wr_en_o    = 1'b1;
      end else if (op_i == OP_BTST) begin
         fl.z       = ~tbit;
         fl.h       = 1'b1;
         flg_mask_o = MASK_TEST;
      end else if (op_i == OP_BCLR) begin
         res_o   = bclr;
         wr_en_o = 1'b1;
      end else if (op_i == OP_BSET) begin
         res_o   = bset;
         wr_en_o = 1'b1;
      end
   end

   assign z_o = fl.z;
   assign n_o = fl.n;
   assign h_o = fl.h;
   assign c_o = fl.c;

endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk #(
   parameter int W  = 8,
   parameter int IW = 3
) (
   input logic [W-1:0]  opnd_i,
   input logic          cy_i,
   input logic [IW-1:0] bidx_i,
   input logic [3:0]    op_i,
   input logic          acc_form_i,
   input logic [W-1:0]  res_o,
   input logic          z_o,
   input logic          n_o,
   input logic          h_o,
   input logic          c_o,
   input logic [3:0]    flg_mask_o,
   input logic          wr_en_o
);

   logic [W-1:0] onehot;
   assign onehot = W'(1) << bidx_i;

   always_comb begin
      if (!flg_mask_o[0]) begin
         assert_c_pass_R9: assert (c_o == cy_i);
      end
      if (!flg_mask_o[3]) begin
         assert_z_quiet_R9: assert (!z_o);
      end
      if (op_i <= 4'd3 && acc_form_i) begin
         assert_short_z_R5: assert (!z_o);
      end
      if (op_i >= 4'd4 && op_i <= 4'd7) begin
         assert_long_z_R4: assert (z_o == (res_o == '0));
         assert_long_nh_R4: assert (!n_o && !h_o && wr_en_o);
      end
      if (op_i == 4'd7) begin
         assert_swap_ones_R6: assert ($countones(res_o) == $countones(opnd_i));
      end
      if (op_i == 4'd8) begin
         assert_test_nowrite_R7: assert (!wr_en_o && res_o == opnd_i && h_o);
      end
      if (op_i == 4'd9 || op_i == 4'd10) begin
         assert_bitmod_local_R8: assert (((res_o ^ opnd_i) & ~onehot) == '0);
         assert_bitmod_value_R8: assert (res_o[bidx_i] == (op_i == 4'd10));
      end
      if (op_i >= 4'd11) begin
         assert_undef_idle_R10: assert (!wr_en_o && flg_mask_o == 4'b0000 && res_o == opnd_i);
      end
   end

endmodule

bind rsb_unit rsb_unit_chk #(.W(W), .IW(IW)) chk_i (
   .opnd_i     (opnd_i),
   .cy_i       (cy_i),
   .bidx_i     (bidx_i),
   .op_i       (op_i),
   .acc_form_i (acc_form_i),
   .res_o      (res_o),
   .z_o        (z_o),
   .n_o        (n_o),
   .h_o        (h_o),
   .c_o        (c_o),
   .flg_mask_o (flg_mask_o),
   .wr_en_o    (wr_en_o)
);

// File: tb/rsb_unit_tb_top.sv
module rsb_unit_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opnd;
   logic       cy;
   logic [2:0] bidx;
   logic [3:0] op;
   logic       accf;
   logic [7:0] res;
   logic       z, n, h, c;
   logic [3:0] mask;
   logic       wr;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   rsb_unit dut_i (
      .opnd_i     (opnd),
      .cy_i       (cy),
      .bidx_i     (bidx),
      .op_i       (op),
      .acc_form_i (accf),
      .res_o      (res),
      .z_o        (z),
      .n_o        (n),
      .h_o        (h),
      .c_o        (c),
      .flg_mask_o (mask),
      .wr_en_o    (wr)
   );

   task automatic drive(input logic [3:0] o, input logic [7:0] v, input logic ci,
                        input logic [2:0] ix, input logic af);
      @(negedge clk);
      op = o; opnd = v; cy = ci; bidx = ix; accf = af;
      #5;
   endtask

   task automatic expect_out(input string tag, input logic [7:0] er,
                             input logic [3:0] ef, input logic [3:0] em,
                             input logic ew);
      total++;
      if (res !== er || {z, n, h, c} !== ef || mask !== em || wr !== ew) begin
         bad++;
         $display("FAIL %s: got res=%h znhc=%b mask=%b wr=%b exp res=%h znhc=%b mask=%b wr=%b",
                  tag, res, {z, n, h, c}, mask, wr, er, ef, em, ew);
      end
   endtask

   task automatic t_idle_after_reset;
      drive(4'd15, 8'h3C, 1'b1, 3'd0, 1'b0);
      expect_out("R10 start idle code 15", 8'h3C, 4'b0001, 4'b0000, 1'b0);
   endtask

   task automatic t_circular;
      drive(4'd0, 8'h85, 1'b0, 3'd0, 1'b0);
      expect_out("R1 rotl circ", 8'h0B, 4'b0001, 4'b1111, 1'b1);
      drive(4'd1, 8'h01, 1'b0, 3'd0, 1'b0);
      expect_out("R1 rotr circ", 8'h80, 4'b0001, 4'b1111, 1'b1);
   endtask

   task automatic t_through;
      drive(4'd2, 8'h80, 1'b0, 3'd0, 1'b0);
      expect_out("R2 rotl thru zero", 8'h00, 4'b1001, 4'b1111, 1'b1);
      drive(4'd2, 8'h40, 1'b1, 3'd0, 1'b0);
      expect_out("R2 rotl thru cin", 8'h81, 4'b0000, 4'b1111, 1'b1);
      drive(4'd3, 8'h02, 1'b1, 3'd0, 1'b0);
      expect_out("R2 rotr thru cin", 8'h81, 4'b0000, 4'b1111, 1'b1);
      drive(4'd3, 8'h01, 1'b0, 3'd0, 1'b0);
      expect_out("R4 rotr thru zero", 8'h00, 4'b1001, 4'b1111, 1'b1);
   endtask

   task automatic t_shifts;
      drive(4'd4, 8'h41, 1'b1, 3'd0, 1'b0);
      expect_out("R3 shl", 8'h82, 4'b0000, 4'b1111, 1'b1);
      drive(4'd5, 8'h81, 1'b0, 3'd0, 1'b0);
      expect_out("R3 shr arith", 8'hC0, 4'b0001, 4'b1111, 1'b1);
      drive(4'd6, 8'h81, 1'b0, 3'd0, 1'b0);
      expect_out("R3 shr logic", 8'h40, 4'b0001, 4'b1111, 1'b1);
      drive(4'd6, 8'h01, 1'b0, 3'd0, 1'b0);
      expect_out("R4 shr logic zero", 8'h00, 4'b1001, 4'b1111, 1'b1);
   endtask

   task automatic t_short_form;
      drive(4'd2, 8'h80, 1'b0, 3'd0, 1'b1);
      expect_out("R5 short rotl thru", 8'h00, 4'b0001, 4'b1111, 1'b1);
      drive(4'd1, 8'h00, 1'b1, 3'd0, 1'b1);
      expect_out("R5 short rotr circ", 8'h00, 4'b0000, 4'b1111, 1'b1);
      drive(4'd4, 8'h80, 1'b0, 3'd0, 1'b1);
      expect_out("R5 flag ignored on shl", 8'h00, 4'b1001, 4'b1111, 1'b1);
   endtask

   task automatic t_swap;
      drive(4'd7, 8'hA5, 1'b1, 3'd0, 1'b0);
      expect_out("R6 swap", 8'h5A, 4'b0000, 4'b1111, 1'b1);
      drive(4'd7, 8'h00, 1'b1, 3'd0, 1'b1);
      expect_out("R6 swap zero", 8'h00, 4'b1000, 4'b1111, 1'b1);
   endtask

   task automatic t_bit_test;
      drive(4'd8, 8'h7F, 1'b1, 3'd7, 1'b0);
      expect_out("R7 test clear bit", 8'h7F, 4'b1011, 4'b1110, 1'b0);
      drive(4'd8, 8'h01, 1'b0, 3'd0, 1'b1);
      expect_out("R7 test set bit", 8'h01, 4'b0010, 4'b1110, 1'b0);
   endtask

   task automatic t_bit_mod;
      drive(4'd9, 8'hFF, 1'b1, 3'd3, 1'b0);
      expect_out("R8 clear bit3", 8'hF7, 4'b0001, 4'b0000, 1'b1);
      drive(4'd10, 8'h00, 1'b0, 3'd0, 1'b0);
      expect_out("R8 set bit0", 8'h01, 4'b0000, 4'b0000, 1'b1);
      drive(4'd10, 8'h80, 1'b1, 3'd7, 1'b0);
      expect_out("R9 set bit7 carry kept", 8'h80, 4'b0001, 4'b0000, 1'b1);
   endtask

   task automatic t_undef;
      for (int k = 11; k < 16; k++) begin
         drive(4'(k), 8'h96, 1'b0, 3'd2, 1'b1);
         expect_out("R10 undefined code", 8'h96, 4'b0000, 4'b0000, 1'b0);
      end
   endtask

   initial begin
      op = 4'd15; opnd = '0; cy = 1'b0; bidx = '0; accf = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle_after_reset();
      t_circular();
      t_through();
      t_shifts();
      t_short_form();
      t_swap();
      t_bit_test();
      t_bit_mod();
      t_undef();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got running exp finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule